// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block drives the control pins of a 128K x 8 ultraviolet-erasable EPROM through the programming of a single byte. The host places an address and a data byte on its inputs and pulses `start` for one cycle. The block captures both values. It then enables the high programming supply and drives the address and data onto the device. After the setup window it issues one bounded, active-low program pulse. It keeps the data on the bus through the hold window and releases the bus. It then reads the byte back with output enable low and compares it with the intended value.

If the read-back byte differs, the sequence repeats with another pulse, up to `MAX_TRIES` pulses in total. Every run ends with a one-cycle `done` strobe. The `pass` output reports the outcome and holds it until the next run starts. The programming supply is switched off before `done` appears. Every interval is a clock-cycle count that is derived at elaboration from `CLK_MHZ`. The pulse length is clamped into the 45 to 105 µs window that the device accepts. Analog supply generation, erase and looping over the address range are left to the surrounding system.

Top module: `eprom_prog_seq`

## Requirements
- R1: Out of reset and whenever `busy` is low, `rom_ce_n`, `rom_oe_n` and `rom_pgm_n` are 1, and `vpp_on` and `rom_wr_en` are 0.
- R2: Before each falling edge of `rom_pgm_n`, the following hold together for at least `SETUP_US*CLK_MHZ` cycles: `rom_addr` and `rom_wr_data` carry the captured address and byte, `rom_wr_en`=1, `rom_ce_n`=0, `rom_oe_n`=1 and `vpp_on`=1.
- R3: Each program pulse holds `rom_pgm_n` low for exactly `clamp(PULSE_US,45,105)*CLK_MHZ` consecutive cycles.
- R4: After `rom_pgm_n` returns high, `rom_wr_en` stays 1 for at least `HOLD_US*CLK_MHZ` cycles. `rom_addr` does not change while `busy` is 1.
- R5: Whenever `rom_pgm_n` is 0, `rom_oe_n`=1, `rom_ce_n`=0 and `vpp_on`=1.
- R6: `rom_wr_en` is never 1 while `rom_oe_n` is 0. It is already 0 in the cycle before `rom_oe_n` falls.
- R7: A verify read holds `rom_oe_n` low, with `rom_ce_n` low, for `ceil(OEV_NS*CLK_MHZ/1000)` cycles (at least 1). `rom_rd_data` is compared with the captured byte in the last of those cycles.
- R8: After `rom_oe_n` rises, `rom_wr_en` stays 0 for at least `ceil(FLOAT_NS*CLK_MHZ/1000)` cycles (at least 1).
- R9: A mismatch at verify triggers another program pulse unless `MAX_TRIES` pulses have already been issued. A device that needs n pulses therefore receives min(n, `MAX_TRIES`) pulses.
- R10: Each run ends with `done`=1 for one cycle, with `vpp_on`=0 in that cycle. `pass`=1 there means the last verify matched and `pass`=0 means the retry limit was exhausted. `pass` holds until the next accepted `start`.
- R11: A `start` pulse while `busy` is 1 is ignored: the captured address, the byte and the pulse count of the run in progress are unchanged.
- R12: `rom_pgm_n` is 1 in every cycle in which `vpp_on` rises, including the first run after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency `CLK_MHZ` MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to program a byte |
| prog_addr | input | ADDR_W | Target address, captured on start |
| prog_data | input | DATA_W | Byte to program, captured on start |
| rom_rd_data | input | DATA_W | Data read back from the device outputs |
| rom_addr | output | ADDR_W | Device address bus |
| rom_wr_data | output | DATA_W | Data presented to the device inputs |
| rom_wr_en | output | 1 | Enable for the host data-bus driver |
| rom_ce_n | output | 1 | Device chip enable, active low |
| rom_oe_n | output | 1 | Device output enable, active low |
| rom_pgm_n | output | 1 | Device program pulse, active low |
| vpp_on | output | 1 | Switches the high programming supply on |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Outcome of the last run |

## Verification
A wrong sequencer state appears at the pins in the same cycle. The registered pin set follows the state. A misordered phase therefore shows up at once as bus contention, as a program pulse with output enable low, or as the supply rising during a pulse. A corrupted interval count surfaces at the end of the phase it times, as a pulse, hold or float window of the wrong length. A wrong compare or retry count surfaces only at `done`. It then shows as a wrong `pass` or a pulse count that differs from min(n, `MAX_TRIES`), one full pulse period or more after the fault.

// File: rtl/eprom_prog_pkg.sv
// Shared types and elaboration-time helpers for the EPROM byte programming
// sequencer. Assumes all timing is expressed in whole clock cycles.
package eprom_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_TURN,
        ST_VERIFY,
        ST_FLOAT,
        ST_FINISH
    } seq_state_t;

    typedef struct packed {
        logic vpp_en;
        logic ce_n;
        logic oe_n;
        logic pgm_n;
        logic drv_en;
    } pin_set_t;

    localparam int PULSE_MIN_US = 45;
    localparam int PULSE_MAX_US = 105;

    // Microseconds to cycles, never less than one cycle.
    function automatic int cyc_from_us(input int mhz, input int us);
        int c;
        c = mhz * us;
        return (c < 1) ? 1 : c;
    endfunction

    // Nanoseconds to cycles, rounded up, never less than one cycle.
    function automatic int cyc_from_ns(input int mhz, input int ns);
        int c;
        c = (mhz * ns + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // Keep the requested pulse width inside the window the device accepts.
    function automatic int clamp_pulse_us(input int us);
        if (us < PULSE_MIN_US) return PULSE_MIN_US;
        if (us > PULSE_MAX_US) return PULSE_MAX_US;
        return us;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prog_interval_timer.sv
// Down-counter that times one sequencer phase.
// Load value N-1 on phase entry; expired is high on the phase's last cycle,
// so the phase lasts N cycles. Assumes load is a single-cycle request.
module prog_interval_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);

    logic [WIDTH-1:0] count_q;

    // Reload on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/prog_try_counter.sv
// Counts program pulses issued in the current run and flags the retry limit.
// Assumes clear and bump are never asserted in the same cycle.
module prog_try_counter #(
    parameter int MAX_TRIES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic at_limit
);

    localparam int CW = $clog2(MAX_TRIES + 1);

    logic [CW-1:0] tries_q;

    // Clear at run start, add one for each pulse issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tries_q <= '0;
        end else if (clear) begin
            tries_q <= '0;
        end else if (bump) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    assign at_limit = (tries_q == CW'(MAX_TRIES));

endmodule

// File: rtl/prog_seq_fsm.sv
// Phase sequencer: setup, pulse, hold, bus turnaround, verify, float, and
// either retry or finish. Pins are registered from the next state so they
// change in step with the state register and never glitch.
// Assumes the timer and try counter respond in the cycle after a request.
module prog_seq_fsm
    import eprom_prog_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int TMR_W     = 8,
    parameter int SETUP_CYC = 1,
    parameter int PW_CYC    = 50,
    parameter int HOLD_CYC  = 1,
    parameter int TURN_CYC  = 1,
    parameter int OEV_CYC   = 1,
    parameter int FLT_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] want_data,
    input  logic              tmr_expired,
    input  logic              at_limit,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output logic              try_clear,
    output logic              try_bump,
    output logic              capture,
    output pin_set_t          pins,
    output logic              busy,
    output logic              done,
    output logic              pass
);

    seq_state_t st_q, st_nxt;
    pin_set_t   pins_q;
    logic       match_q;
    logic       pass_q;

    // Pin levels that belong to each phase.
    function automatic pin_set_t pins_for(input seq_state_t s);
        pin_set_t p;
        p = '{vpp_en: 1'b0, ce_n: 1'b1, oe_n: 1'b1, pgm_n: 1'b1, drv_en: 1'b0};
        case (s)
            ST_SETUP, ST_HOLD: begin
                p.vpp_en = 1'b1;
                p.ce_n   = 1'b0;
                p.drv_en = 1'b1;
            end
            ST_PULSE: begin
                p.vpp_en = 1'b1;
                p.ce_n   = 1'b0;
                p.drv_en = 1'b1;
                p.pgm_n  = 1'b0;
            end
            ST_TURN, ST_FLOAT: begin
                p.vpp_en = 1'b1;
                p.ce_n   = 1'b0;
            end
            ST_VERIFY: begin
                p.vpp_en = 1'b1;
                p.ce_n   = 1'b0;
                p.oe_n   = 1'b0;
            end
            default: ;
        endcase
        return p;
    endfunction

    // Next phase, timer reload and counter requests.
    always_comb begin
        st_nxt    = st_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        try_clear = 1'b0;
        try_bump  = 1'b0;
        capture   = 1'b0;
        case (st_q)
            ST_IDLE: if (start) begin
                st_nxt    = ST_SETUP;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(SETUP_CYC - 1);
                try_clear = 1'b1;
                capture   = 1'b1;
            end
            ST_SETUP: if (tmr_expired) begin
                st_nxt   = ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(PW_CYC - 1);
                try_bump = 1'b1;
            end
            ST_PULSE: if (tmr_expired) begin
                st_nxt   = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(HOLD_CYC - 1);
            end
            ST_HOLD: if (tmr_expired) begin
                st_nxt   = ST_TURN;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(TURN_CYC - 1);
            end
            ST_TURN: if (tmr_expired) begin
                st_nxt   = ST_VERIFY;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(OEV_CYC - 1);
            end
            ST_VERIFY: if (tmr_expired) begin
                st_nxt   = ST_FLOAT;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(FLT_CYC - 1);
            end
            ST_FLOAT: if (tmr_expired) begin
                if (match_q || at_limit) begin
                    st_nxt = ST_FINISH;
                end else begin
                    st_nxt   = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SETUP_CYC - 1);
                end
            end
            ST_FINISH: st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // State and registered pin set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pins_q <= pins_for(ST_IDLE);
        end else begin
            st_q   <= st_nxt;
            pins_q <= pins_for(st_nxt);
        end
    end

    // Verify compare in the last output-enable cycle and run outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            if (capture) begin
                match_q <= 1'b0;
                pass_q  <= 1'b0;
            end else if (st_q == ST_VERIFY && tmr_expired) begin
                match_q <= (rd_data == want_data);
            end
            if (st_q == ST_FLOAT && st_nxt == ST_FINISH) begin
                pass_q <= match_q;
            end
        end
    end

    assign pins = pins_q;
    assign busy = (st_q != ST_IDLE);
    assign done = (st_q == ST_FINISH);
    assign pass = pass_q;

endmodule

// File: rtl/eprom_prog_seq.sv
// Top level of the EPROM byte programming sequencer. Captures the request,
// derives every interval from CLK_MHZ and wires the phase sequencer to its
// timer and try counter. Assumes the device outputs are valid on
// rom_rd_data within OEV_NS of output enable falling.
module eprom_prog_seq #(
    parameter int CLK_MHZ   = 100,
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int MAX_TRIES = 25,
    parameter int PULSE_US  = 50,
    parameter int SETUP_US  = 1,
    parameter int HOLD_US   = 1,
    parameter int OEV_NS    = 100,
    parameter int FLOAT_NS  = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [DATA_W-1:0] rom_rd_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [DATA_W-1:0] rom_wr_data,
    output logic              rom_wr_en,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              rom_pgm_n,
    output logic              vpp_on,
    output logic              busy,
    output logic              done,
    output logic              pass
);
    import eprom_prog_pkg::*;

    localparam int SETUP_CYC = cyc_from_us(CLK_MHZ, SETUP_US);
    localparam int PW_CYC    = cyc_from_us(CLK_MHZ, clamp_pulse_us(PULSE_US));
    localparam int HOLD_CYC  = cyc_from_us(CLK_MHZ, HOLD_US);
    localparam int TURN_CYC  = 1;
    localparam int OEV_CYC   = cyc_from_ns(CLK_MHZ, OEV_NS);
    localparam int FLT_CYC   = cyc_from_ns(CLK_MHZ, FLOAT_NS);
    localparam int LONGEST   = max2(max2(max2(SETUP_CYC, PW_CYC), max2(HOLD_CYC, TURN_CYC)),
                                    max2(OEV_CYC, FLT_CYC));
    localparam int TMR_W     = $clog2(LONGEST + 1);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              tmr_load, tmr_expired;
    logic [TMR_W-1:0]  tmr_val;
    logic              try_clear, try_bump, at_limit, capture;
    pin_set_t          pins;

    // Hold the request for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (capture) begin
            addr_q <= prog_addr;
            data_q <= prog_data;
        end
    end

    prog_interval_timer #(.WIDTH(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    prog_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (try_clear),
        .bump     (try_bump),
        .at_limit (at_limit)
    );

    prog_seq_fsm #(
        .DATA_W    (DATA_W),
        .TMR_W     (TMR_W),
        .SETUP_CYC (SETUP_CYC),
        .PW_CYC    (PW_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .TURN_CYC  (TURN_CYC),
        .OEV_CYC   (OEV_CYC),
        .FLT_CYC   (FLT_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rd_data     (rom_rd_data),
        .want_data   (data_q),
        .tmr_expired (tmr_expired),
        .at_limit    (at_limit),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .try_clear   (try_clear),
        .try_bump    (try_bump),
        .capture     (capture),
        .pins        (pins),
        .busy        (busy),
        .done        (done),
        .pass        (pass)
    );

    assign rom_addr    = addr_q;
    assign rom_wr_data = data_q;
    assign rom_wr_en   = pins.drv_en;
    assign rom_ce_n    = pins.ce_n;
    assign rom_oe_n    = pins.oe_n;
    assign rom_pgm_n   = pins.pgm_n;
    assign vpp_on      = pins.vpp_en;

endmodule

// File: rtl/prog_seq_checker.sv
// Pin-level protocol checks for the EPROM byte programming sequencer,
// bound to the top module. Window lengths are tracked with counters.
module prog_seq_checker #(
    parameter int CLK_MHZ  = 100,
    parameter int PULSE_US = 50,
    parameter int FLOAT_NS = 60,
    parameter int ADDR_W   = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_wr_en,
    input logic              rom_ce_n,
    input logic              rom_oe_n,
    input logic              rom_pgm_n,
    input logic              vpp_on,
    input logic              busy,
    input logic              done
);
    import eprom_prog_pkg::*;

    localparam int PW  = cyc_from_us(CLK_MHZ, clamp_pulse_us(PULSE_US));
    localparam int FLT = cyc_from_ns(CLK_MHZ, FLOAT_NS);

    logic [31:0] low_cnt;
    logic [31:0] gap_cnt;

    // Length of the current program pulse so far.
    always_ff @(posedge clk) begin
        if (!rst_n) low_cnt <= '0;
        else        low_cnt <= rom_pgm_n ? 32'd0 : low_cnt + 32'd1;
    end

    // Cycles with output enable high since it was last low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)         gap_cnt <= 32'(FLT);
        else if (!rom_oe_n) gap_cnt <= '0;
        else if (gap_cnt < 32'(FLT)) gap_cnt <= gap_cnt + 32'd1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rom_pgm_n && rom_oe_n && rom_ce_n && !vpp_on && !rom_wr_en));

    p_pulse_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_pgm_n |-> (low_cnt < 32'(PW)));

    p_pulse_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_pgm_n) |-> (low_cnt == 32'(PW)));

    p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rom_addr));

    p_pulse_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_pgm_n |-> (rom_oe_n && !rom_ce_n && vpp_on));

    p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> !rom_wr_en);

    p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_oe_n) |-> !$past(rom_wr_en));

    p_float_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_wr_en) |-> (gap_cnt >= 32'(FLT)));

    p_done_supply_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !vpp_on);

    p_supply_order_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vpp_on) |-> rom_pgm_n);

endmodule

bind eprom_prog_seq prog_seq_checker #(
    .CLK_MHZ  (CLK_MHZ),
    .PULSE_US (PULSE_US),
    .FLOAT_NS (FLOAT_NS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rom_addr  (rom_addr),
    .rom_wr_en (rom_wr_en),
    .rom_ce_n  (rom_ce_n),
    .rom_oe_n  (rom_oe_n),
    .rom_pgm_n (rom_pgm_n),
    .vpp_on    (vpp_on),
    .busy      (busy),
    .done      (done)
);

// File: tb/eprom_prog_seq_test.sv
// Sweeps pulses-needed x data patterns on a 2 MHz-equivalent configuration,
// with a bench model of the device that reads back correctly only after a
// chosen number of program pulses.
module eprom_prog_seq_test;

    localparam int MHZ   = 2;
    localparam int PUS   = 50;
    localparam int TRIES = 3;
    localparam int AW    = 17;
    localparam int DW    = 8;

    localparam int SETUP_EXP = MHZ * 1;
    localparam int PW_EXP    = MHZ * PUS;
    localparam int HOLD_EXP  = MHZ * 1;
    localparam int OEV_RAW   = (MHZ * 100 + 999) / 1000;
    localparam int OEV_EXP   = (OEV_RAW < 1) ? 1 : OEV_RAW;
    localparam int FLT_RAW   = (MHZ * 60 + 999) / 1000;
    localparam int FLT_EXP   = (FLT_RAW < 1) ? 1 : FLT_RAW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;
    logic [DW-1:0] rom_rd_data;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_wr_data;
    logic          rom_wr_en, rom_ce_n, rom_oe_n, rom_pgm_n, vpp_on;
    logic          busy, done, pass;

    int            checks = 0;
    int            errors = 0;
    int            need   = 1;
    int            pulses = 0;
    logic [DW-1:0] cur_data = '0;
    logic [AW-1:0] cur_addr = '0;
    bit            finished = 1'b0;

    always #5 clk = ~clk;

    // Device model: bits read back right only after enough pulses.
    assign rom_rd_data = (!rom_ce_n && !rom_oe_n) ?
                         ((pulses >= need) ? cur_data : ~cur_data) : 8'hFF;

    eprom_prog_seq #(
        .CLK_MHZ   (MHZ),
        .ADDR_W    (AW),
        .DATA_W    (DW),
        .MAX_TRIES (TRIES),
        .PULSE_US  (PUS)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .rom_rd_data (rom_rd_data),
        .rom_addr    (rom_addr),
        .rom_wr_data (rom_wr_data),
        .rom_wr_en   (rom_wr_en),
        .rom_ce_n    (rom_ce_n),
        .rom_oe_n    (rom_oe_n),
        .rom_pgm_n   (rom_pgm_n),
        .vpp_on      (vpp_on),
        .busy        (busy),
        .done        (done),
        .pass        (pass)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Pin monitor sampled between edges.
    logic prev_pgm = 1'b1, prev_doe = 1'b0, prev_oe = 1'b1, prev_vpp = 1'b0;
    int   pre_cnt = 0, low_cnt = 0, post_cnt = 0, flt_cnt = 0, oe_cnt = 0;
    bit   after_pulse = 0, seen_verify = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_pgm = 1'b1; prev_doe = 1'b0; prev_oe = 1'b1; prev_vpp = 1'b0;
            pre_cnt = 0; low_cnt = 0; post_cnt = 0; flt_cnt = 0; oe_cnt = 0;
            after_pulse = 0; seen_verify = 0;
        end else begin
            if (!rom_oe_n && rom_wr_en)
                chk(1'b0, "R6", "driver on during read", 1, 0);
            if (!prev_vpp && vpp_on)
                chk(rom_pgm_n, "R12", "pgm_n when supply rises", int'(rom_pgm_n), 1);
            if (prev_pgm && !rom_pgm_n) begin
                pulses++;
                chk(pre_cnt >= SETUP_EXP, "R2", "setup cycles", pre_cnt, SETUP_EXP);
                chk(rom_addr == cur_addr, "R2", "address at pulse", int'(rom_addr), int'(cur_addr));
                chk(rom_wr_data == cur_data, "R2", "data at pulse", int'(rom_wr_data), int'(cur_data));
            end
            if (!rom_pgm_n) begin
                low_cnt++;
                if (!rom_oe_n || rom_ce_n || !vpp_on)
                    chk(1'b0, "R5", "pins during pulse", int'({rom_oe_n, rom_ce_n, vpp_on}), 3'b101);
            end
            if (!prev_pgm && rom_pgm_n) begin
                chk(low_cnt == PW_EXP, "R3", "pulse width", low_cnt, PW_EXP);
                low_cnt = 0; after_pulse = 1; post_cnt = 0;
            end
            if (prev_doe && !rom_wr_en && after_pulse) begin
                chk(post_cnt >= HOLD_EXP, "R4", "hold cycles", post_cnt, HOLD_EXP);
                after_pulse = 0;
            end
            if (after_pulse && rom_pgm_n && rom_wr_en) post_cnt++;
            if (prev_oe && !rom_oe_n) begin
                chk(!prev_doe && !rom_ce_n, "R6", "turnaround before read", int'(prev_doe), 0);
                oe_cnt = 0;
            end
            if (!rom_oe_n) oe_cnt++;
            if (!prev_oe && rom_oe_n) begin
                chk(oe_cnt == OEV_EXP, "R7", "read length", oe_cnt, OEV_EXP);
                flt_cnt = 0; seen_verify = 1;
            end
            if (!prev_doe && rom_wr_en && seen_verify) begin
                chk(flt_cnt >= FLT_EXP, "R8", "float gap", flt_cnt, FLT_EXP);
                seen_verify = 0;
            end
            if (seen_verify && rom_oe_n && !rom_wr_en) flt_cnt++;
            if (rom_pgm_n && vpp_on && rom_wr_en && !rom_ce_n && rom_oe_n) pre_cnt++;
            else pre_cnt = 0;
            prev_pgm = rom_pgm_n; prev_doe = rom_wr_en; prev_oe = rom_oe_n; prev_vpp = vpp_on;
        end
    end

    task automatic check_quiet(input string req);
        chk(rom_pgm_n && rom_oe_n && rom_ce_n && !vpp_on && !rom_wr_en && !busy,
            req, "idle pins {pgm,oe,ce,vpp,drv,busy}",
            int'({rom_pgm_n, rom_oe_n, rom_ce_n, vpp_on, rom_wr_en, busy}), 6'b111000);
    endtask

    // One programming run; poke issues a stray start while busy (R11).
    task automatic run(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int nd, input bit poke);
        int  exp_p;
        bit  exp_pass;
        int  waited;
        bit  saw_done;
        cur_addr = a; cur_data = d; need = nd; pulses = 0;
        prog_addr = a; prog_data = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0; prog_addr = ~a; prog_data = ~d;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        saw_done = done;
        while (!saw_done && waited < 3000) begin
            @(negedge clk);
            waited++;
            saw_done = done;
        end
        exp_pass = (nd <= TRIES);
        exp_p    = exp_pass ? nd : TRIES;
        chk(saw_done, "R10", "done strobe", int'(saw_done), 1);
        chk(pass == exp_pass, "R10", "pass result", int'(pass), int'(exp_pass));
        chk(pulses == exp_p, "R9", "pulse count", pulses, exp_p);
        chk(!vpp_on, "R10", "supply off at done", int'(vpp_on), 0);
        if (poke)
            chk(rom_addr == a, "R11", "address after stray start", int'(rom_addr), int'(a));
        @(negedge clk);
        chk(!done, "R10", "done one cycle", int'(done), 0);
        chk(pass == exp_pass, "R10", "pass held", int'(pass), int'(exp_pass));
        check_quiet("R1");
    endtask

    initial begin
        logic [DW-1:0] pats [5];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A; pats[4] = 8'h3C;
        rst_n = 1'b0; start = 1'b0; prog_addr = '0; prog_data = '0;
        repeat (3) @(negedge clk);
        check_quiet("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1");
        for (int nd = 1; nd <= TRIES + 1; nd++) begin
            for (int p = 0; p < 5; p++) begin
                run(AW'((nd * 5 + p) * 40503), pats[p], nd, 1'b0);
            end
        end
        run(17'h1FFFF, 8'h81, 2, 1'b1);
        run(17'h00000, 8'h7E, TRIES + 1, 1'b1);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule